// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the register exchange between a host bus and the embedded CPU of an 8042-style keyboard controller. The host writes bytes into an input data register. Each host write also records host address bit 2, which marks the byte as a command (1) or as data (0). The embedded CPU places bytes for the host in an output data register. Both sides see one status byte. That byte carries the output-full flag, the input-full flag and the command/data marker.

Two interrupt lines leave the block: a keyboard line and a mouse line. Each has a control bit in an 8-bit CPU port register. Before the CPU issues its enable-flags strobe, each line simply repeats its port bit. After the strobe, the keyboard line shows the output-full flag and the mouse line shows the inverse of the input-full flag. In that state each line is still masked by its port bit. The enable-flags state is sticky until reset.

Top module: `kbc_mailbox`

## Requirements
- R1: A host write (host_wr) stores host_wdata into the input data register and sets the input-full flag (status bit 1) at the next clock edge. The stored byte appears on cpu_in_data.
- R2: On each host write, status bit 3 takes the value of host_addr2 (1 = command, 0 = data). It keeps that value until the next host write.
- R3: A CPU write (cpu_out_wr) stores cpu_out_data and sets the output-full flag (status bit 0) at the next edge. While host_addr2 is 0, host_rdata returns the stored byte.
- R4: A host read with host_addr2 = 0 clears the output-full flag at the next edge. A host read with host_addr2 = 1 returns the status byte on host_rdata and changes no flag.
- R5: A CPU read of the input data register (cpu_in_rd) clears the input-full flag at the next edge.
- R6: If a flag is set and cleared in the same cycle, the set wins. A host write together with cpu_in_rd leaves the input-full flag at 1. A CPU write together with a host data read leaves the output-full flag at 1.
- R7: With enable-flags active, kbd_irq equals port bit 4 AND the output-full flag.
- R8: With enable-flags active, mouse_irq equals port bit 5 AND NOT the input-full flag.
- R9: Without enable-flags, kbd_irq equals port bit 4 and mouse_irq equals port bit 5, whatever the flags hold.
- R10: Reset clears the port register, both flags, the command marker and enable-flags, so both interrupts read 0. Enable-flags is set by cpu_en_flags and cleared only by reset.
- R11: The status byte is laid out as: bit 0 output-full, bit 1 input-full, bit 3 command/data, all other bits 0. cpu_status carries the same byte as a host status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr2 | input | 1 | Host address bit 2: 1 = command/status, 0 = data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Output data (addr2 = 0) or status (addr2 = 1) |
| cpu_out_wr | input | 1 | CPU write strobe for the output data register |
| cpu_out_data | input | 8 | CPU byte for the host |
| cpu_in_rd | input | 1 | CPU read strobe for the input data register |
| cpu_in_data | output | 8 | Last byte written by the host |
| cpu_status | output | 8 | Status byte seen by the CPU |
| cpu_port_wr | input | 1 | CPU write strobe for the port register |
| cpu_port_data | input | 8 | Port register write value |
| port_q | output | 8 | Current port register value |
| cpu_en_flags | input | 1 | Enable-flags strobe |
| kbd_irq | output | 1 | Keyboard interrupt |
| mouse_irq | output | 1 | Mouse interrupt |

## Verification
Two pairs of events can collide in one cycle, each acting on the same flag from opposite sides. A host write can meet a CPU read of the input register. A CPU write can meet a host read of the output register. The bench drives each pair together on one edge. It then expects the flag to read 1 and the data register to hold the new byte. Interrupt routing is swept over every combination of the two port bits and the two flags, both before and after the enable-flags strobe.

// File: rtl/kbc_mbx_pkg.sv
package kbc_mbx_pkg;

    localparam int DATA_W   = 8;
    localparam int IRQ_N    = 2;
    localparam int KBD_CH   = 0;
    localparam int MOUSE_CH = 1;

    typedef struct packed {
        logic [3:0] spare_hi;
        logic       cmd;
        logic       spare_lo;
        logic       ibf;
        logic       obf;
    } kbc_status_t;

    typedef enum logic {
        SRC_OBF   = 1'b0,
        SRC_IBF_N = 1'b1
    } irq_src_e;

    function automatic int irq_port_bit(input int ch);
        return (ch == KBD_CH) ? 4 : 5;
    endfunction

    function automatic irq_src_e irq_src(input int ch);
        return (ch == KBD_CH) ? SRC_OBF : SRC_IBF_N;
    endfunction

    function automatic kbc_status_t pack_status(input logic obf, input logic ibf,
                                                input logic cmd);
        kbc_status_t s;
        s          = '0;
        s.obf      = obf;
        s.ibf      = ibf;
        s.cmd      = cmd;
        return s;
    endfunction

endpackage

// File: rtl/kbc_in_buf.sv
module kbc_in_buf
    import kbc_mbx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_wr,
    input  logic         host_addr2,
    input  logic [W-1:0] host_wdata,
    input  logic         cpu_rd,
    output logic [W-1:0] data_q,
    output logic         ibf_q,
    output logic         cmd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            ibf_q  <= 1'b0;
            cmd_q  <= 1'b0;
        end else begin
            if (host_wr) begin
                data_q <= host_wdata;
                cmd_q  <= host_addr2;
                ibf_q  <= 1'b1;
            end else if (cpu_rd) begin
                ibf_q  <= 1'b0;
            end
        end
    end

    // R1 / R6: a host write always leaves the flag set
    a_r1_wr_sets_ibf: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> ibf_q);
    // R2: command marker follows address bit 2
    a_r2_cmd_follows_addr: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (cmd_q == $past(host_addr2)));
    // R5: a lone CPU read clears the flag
    a_r5_rd_clears_ibf: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !host_wr) |=> !ibf_q);

endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
    import kbc_mbx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cpu_wr,
    input  logic [W-1:0] cpu_wdata,
    input  logic         host_data_rd,
    output logic [W-1:0] data_q,
    output logic         obf_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            obf_q  <= 1'b0;
        end else begin
            if (cpu_wr) begin
                data_q <= cpu_wdata;
                obf_q  <= 1'b1;
            end else if (host_data_rd) begin
                obf_q  <= 1'b0;
            end
        end
    end

    // R3 / R6: a CPU write always leaves the flag set
    a_r3_wr_sets_obf: assert property (@(posedge clk) disable iff (rst)
        cpu_wr |=> obf_q);
    // R4: a lone host data read clears the flag
    a_r4_rd_clears_obf: assert property (@(posedge clk) disable iff (rst)
        (host_data_rd && !cpu_wr) |=> !obf_q);
    // R4: without either event the flag holds
    a_r4_obf_holds: assert property (@(posedge clk) disable iff (rst)
        (!host_data_rd && !cpu_wr) |=> $stable(obf_q));

endmodule

// File: rtl/kbc_irq_route.sv
module kbc_irq_route
    import kbc_mbx_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = IRQ_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         port_wr,
    input  logic [W-1:0] port_wdata,
    input  logic         en_strobe,
    input  logic         obf,
    input  logic         ibf,
    output logic [W-1:0] port_q,
    output logic         en_q,
    output logic [N-1:0] irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (port_wr)   port_q <= port_wdata;
            if (en_strobe) en_q   <= 1'b1;
        end
    end

    for (genvar ch = 0; ch < N; ch++) begin : g_chan
        localparam int       PB  = irq_port_bit(ch);
        localparam irq_src_e SRC = irq_src(ch);
        logic flag_src;
        if (SRC == SRC_OBF) begin : g_obf
            assign flag_src = obf;
        end else begin : g_ibf_n
            assign flag_src = ~ibf;
        end
        assign irq[ch] = en_q ? (port_q[PB] & flag_src) : port_q[PB];
    end

    // R10: enable-flags is sticky until reset
    a_r10_en_sticky: assert property (@(posedge clk) disable iff (rst)
        en_q |=> en_q);
    a_r10_en_strobe: assert property (@(posedge clk) disable iff (rst)
        en_strobe |=> en_q);

endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
    import kbc_mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_addr2,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       cpu_out_wr,
    input  logic [7:0] cpu_out_data,
    input  logic       cpu_in_rd,
    output logic [7:0] cpu_in_data,
    output logic [7:0] cpu_status,
    input  logic       cpu_port_wr,
    input  logic [7:0] cpu_port_data,
    output logic [7:0] port_q,
    input  logic       cpu_en_flags,
    output logic       kbd_irq,
    output logic       mouse_irq
);

    logic        ibf, obf, cmd, en_flags;
    logic [7:0]  out_q;
    logic [IRQ_N-1:0] irq_v;
    kbc_status_t status;
    logic        host_data_rd;

    assign host_data_rd = host_rd && !host_addr2;

    kbc_in_buf #(.W(DATA_W)) u_in (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_addr2(host_addr2), .host_wdata(host_wdata),
        .cpu_rd(cpu_in_rd),
        .data_q(cpu_in_data), .ibf_q(ibf), .cmd_q(cmd)
    );

    kbc_out_buf #(.W(DATA_W)) u_out (
        .clk(clk), .rst(rst),
        .cpu_wr(cpu_out_wr), .cpu_wdata(cpu_out_data),
        .host_data_rd(host_data_rd),
        .data_q(out_q), .obf_q(obf)
    );

    kbc_irq_route #(.W(DATA_W), .N(IRQ_N)) u_irq (
        .clk(clk), .rst(rst),
        .port_wr(cpu_port_wr), .port_wdata(cpu_port_data),
        .en_strobe(cpu_en_flags),
        .obf(obf), .ibf(ibf),
        .port_q(port_q), .en_q(en_flags), .irq(irq_v)
    );

    assign status     = pack_status(obf, ibf, cmd);
    assign cpu_status = status;
    assign host_rdata = host_addr2 ? status : out_q;
    assign kbd_irq    = irq_v[KBD_CH];
    assign mouse_irq  = irq_v[MOUSE_CH];

    // R7: in flag mode an empty output buffer keeps the keyboard line low
    a_r7_kbd_gated: assert property (@(posedge clk) disable iff (rst)
        (en_flags && !obf) |-> !kbd_irq);
    // R8: in flag mode a full input buffer keeps the mouse line low
    a_r8_mouse_gated: assert property (@(posedge clk) disable iff (rst)
        (en_flags && ibf) |-> !mouse_irq);
    // R11: unused status bits stay zero
    a_r11_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (cpu_status[7:4] == 4'h0) && !cpu_status[2]);

endmodule

// File: tb/sim_kbc_mailbox.sv
module sim_kbc_mailbox;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 0, host_rd = 0, host_addr2 = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic       cpu_out_wr = 0, cpu_in_rd = 0, cpu_port_wr = 0, cpu_en_flags = 0;
    logic [7:0] cpu_out_data = 0, cpu_in_data, cpu_status, cpu_port_data = 0, port_q;
    logic       kbd_irq, mouse_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    kbc_mailbox u0 (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr2(host_addr2),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cpu_out_wr(cpu_out_wr), .cpu_out_data(cpu_out_data),
        .cpu_in_rd(cpu_in_rd), .cpu_in_data(cpu_in_data), .cpu_status(cpu_status),
        .cpu_port_wr(cpu_port_wr), .cpu_port_data(cpu_port_data), .port_q(port_q),
        .cpu_en_flags(cpu_en_flags), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; cpu_out_wr = 0; cpu_in_rd = 0;
        cpu_port_wr = 0; cpu_en_flags = 0;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        repeat (3) tick();
        rst = 0;
    endtask

    // port bits 4/5 from pb, output-full from of, input-full from ib, one edge
    task automatic set_state(logic [1:0] pb, logic of, logic ib);
        cpu_port_wr = 1; cpu_port_data = {2'b00, pb, 4'h0};
        host_addr2 = 0;
        if (of) begin cpu_out_wr = 1; cpu_out_data = 8'h3C; end
        else host_rd = 1;
        if (ib) begin host_wr = 1; host_wdata = 8'hC3; end
        else cpu_in_rd = 1;
        tick();
        idle();
    endtask

    task automatic sweep_irq(logic en);
        for (int pb = 0; pb < 4; pb++)
            for (int of = 0; of < 2; of++)
                for (int ib = 0; ib < 2; ib++) begin
                    logic [1:0] p;
                    p = pb[1:0];
                    set_state(p, of[0], ib[0]);
                    if (en) begin
                        chk("R7 kbd_irq flag mode", {7'b0, kbd_irq}, {7'b0, p[0] & of[0]});
                        chk("R8 mouse_irq flag mode", {7'b0, mouse_irq}, {7'b0, p[1] & ~ib[0]});
                    end else begin
                        chk("R9 kbd_irq direct", {7'b0, kbd_irq}, {7'b0, p[0]});
                        chk("R9 mouse_irq direct", {7'b0, mouse_irq}, {7'b0, p[1]});
                    end
                end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10 reset state
        host_addr2 = 1;
        #1;
        chk("R10 status after reset", host_rdata, 8'h00);
        chk("R10 port after reset", port_q, 8'h00);
        chk("R10 irqs after reset", {6'b0, mouse_irq, kbd_irq}, 8'h00);

        // R1 / R2 / R5: host writes across data values and both address kinds
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d;
            d = 8'((i * 17) ^ 8'h5A);
            host_wr = 1; host_addr2 = i[0]; host_wdata = d;
            tick(); idle();
            chk("R1 cpu_in_data", cpu_in_data, d);
            chk("R1 input-full set", {7'b0, cpu_status[1]}, 8'h01);
            chk("R2 command marker", {7'b0, cpu_status[3]}, {7'b0, i[0]});
            cpu_in_rd = 1;
            tick(); idle();
            chk("R5 input-full cleared", {7'b0, cpu_status[1]}, 8'h00);
            chk("R2 marker held", {7'b0, cpu_status[3]}, {7'b0, i[0]});
        end

        // R3 / R4: CPU writes, status reads without effect, data reads clear
        for (int i = 0; i < 8; i++) begin
            logic [7:0] d;
            d = 8'(8'hA1 + i * 29);
            cpu_out_wr = 1; cpu_out_data = d;
            tick(); idle();
            chk("R3 output-full set", {7'b0, cpu_status[0]}, 8'h01);
            host_rd = 1; host_addr2 = 1;
            #1;
            chk("R4 status read value", host_rdata, cpu_status);
            tick(); idle();
            chk("R4 status read keeps output-full", {7'b0, cpu_status[0]}, 8'h01);
            host_rd = 1; host_addr2 = 0;
            #1;
            chk("R3 host data read", host_rdata, d);
            tick(); idle();
            chk("R4 output-full cleared", {7'b0, cpu_status[0]}, 8'h00);
        end

        // R6: same-cycle set and clear
        host_wr = 1; host_addr2 = 0; host_wdata = 8'h77; cpu_in_rd = 1;
        cpu_out_wr = 1; cpu_out_data = 8'h99; host_rd = 1;
        tick(); idle();
        chk("R6 input-full wins", {7'b0, cpu_status[1]}, 8'h01);
        chk("R6 input data new", cpu_in_data, 8'h77);
        chk("R6 output-full wins", {7'b0, cpu_status[0]}, 8'h01);
        host_addr2 = 0;
        #1;
        chk("R6 output data new", host_rdata, 8'h99);

        // R11: layout with every flag set
        host_wr = 1; host_addr2 = 1; host_wdata = 8'h01;
        tick(); idle();
        host_addr2 = 1;
        #1;
        chk("R11 status layout host", host_rdata, 8'h0B);
        chk("R11 status layout cpu", cpu_status, 8'h0B);

        // R9 then R7 / R8
        sweep_irq(1'b0);
        cpu_en_flags = 1;
        tick(); idle();
        sweep_irq(1'b1);

        // R10: enable-flags persists, then reset clears it
        repeat (20) tick();
        set_state(2'b01, 1'b0, 1'b0);
        chk("R10 flag mode persists", {7'b0, kbd_irq}, 8'h00);
        do_reset();
        chk("R10 irqs low after reset", {6'b0, mouse_irq, kbd_irq}, 8'h00);
        set_state(2'b11, 1'b0, 1'b1);
        chk("R10 reset cleared flag mode kbd", {7'b0, kbd_irq}, 8'h01);
        chk("R10 reset cleared flag mode mouse", {7'b0, mouse_irq}, 8'h01);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule